// File: doc/BRIEF.md
# Flash Sector-Protection Command Sequencer

This block is the write-command front end of a byte-wide parallel NOR flash, limited to the sector-protection command sets. It watches host write cycles, recognises a two-cycle unlock prefix followed by a set-selection code, and then runs the commands of that set. The sets cover a one-time-programmable lock register, a 64-bit password with an unlock procedure, non-volatile per-sector protection bits, a lock bit that freezes those bits, and volatile per-sector protection bits. An exit sequence brings the device back to array-read mode.

The host side is a synchronous bus-cycle port: a write strobe with address and data, and a read strobe whose byte appears on `rd_data` one clock later. The address holds a 12-bit command field in its low bits and the sector number directly above it. Array contents are not modelled: array reads return the erased value FFh. The number of sectors is a parameter.

Top module: `flash_prot_seq`

## Requirements
- R1: After reset the block is in array-read mode (`cmd_mode` = 0), the lock register reads FFh, all per-sector bits are clear and the protection lock is clear.
- R2: A set is entered by three writes: AAh at command address AAAh, 55h at 555h, then a code at AAAh (40h lock register, `cmd_mode` 1; 60h password, 2; C0h persistent bits, 3; 50h protection lock, 4; E0h volatile bits, 5). Address bits above the low 12 are ignored for these compares; a mismatching cycle or an unknown code leaves the block in read mode.
- R3: Inside a set, writing 90h then 00h at any address returns to read mode; any other write in place of 00h returns to the set, and writes that start no command leave the set unchanged.
- R4: In the lock-register set, A0h followed by a data byte ANDs data bits 2:0 into the register (bits only go from 1 to 0); a read returns bits 7:3 as 1 and bits 2:0 as the register.
- R5: A lock-register program whose data has bits 1 and 2 both 0 changes nothing and returns the block to read mode.
- R6: In the password set, A0h followed by a write at byte index addr[2:0] ANDs the data into that password byte (power-up value FFh); a read returns the byte at addr[2:0].
- R7: Password unlock is 25h, 03h, eight byte writes (index addr[2:0], any order), then 29h; it clears the protection lock only if all eight indices were written and every byte matched.
- R8: In the persistent set, A0h then 00h at a sector address marks that sector protected; a read at a sector address returns 00h when protected and 01h when not.
- R9: In the persistent set, 80h then 30h leaves every persistent bit clear.
- R10: In the protection-lock set, A0h then 00h sets the lock; reads return 00h when set and 01h when clear; while set, persistent program and erase have no effect.
- R11: In the volatile set, A0h then 00h at a sector address sets its bit and A0h then 01h clears it, except that a clear is refused while that sector's persistent bit is set; reads return 00h for set, 01h for clear.
- R12: A read strobe yields its byte on `rd_data` at the next clock; in read mode the byte is FFh, and status reads return only 00h or 01h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read cycle strobe |
| addr | input | 12+log2(SECTORS) | Command field in bits 11:0, sector number above |
| wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Read data, valid the clock after `rd_en` |
| cmd_mode | output | 3 | Active set code, 0 for array-read mode |

## Verification
Every write takes effect on the clock edge that samples it, so both `cmd_mode` and the stored bits are due one edge after the write strobe; read data arrives one edge after the read strobe. The bench drives each strobe on a falling edge for one cycle and compares at the following falling edge, which lies after exactly one rising edge, so mode checks land right after the last write of a sequence and read checks right after the read strobe. State that a refused or ignored command could have touched is read back through the status reads of the matching set before any further command.

// File: rtl/fps_pkg.sv
package fps_pkg;

   typedef enum logic [2:0] {
      SET_RD   = 3'd0,
      SET_LOCK = 3'd1,
      SET_PWD  = 3'd2,
      SET_PPB  = 3'd3,
      SET_PLK  = 3'd4,
      SET_DYB  = 3'd5
   } set_e;

   localparam logic [11:0] CMD_ADR_A = 12'hAAA;
   localparam logic [11:0] CMD_ADR_B = 12'h555;
   localparam logic [7:0]  KEY_A     = 8'hAA;
   localparam logic [7:0]  KEY_B     = 8'h55;
   localparam logic [7:0]  OP_PROG   = 8'hA0;
   localparam logic [7:0]  OP_EXIT   = 8'h90;
   localparam logic [7:0]  OP_ERASE  = 8'h80;
   localparam logic [7:0]  OP_ERGO   = 8'h30;
   localparam logic [7:0]  OP_PWU_A  = 8'h25;
   localparam logic [7:0]  OP_PWU_B  = 8'h03;
   localparam logic [7:0]  OP_PWU_Z  = 8'h29;

   // one-cycle command strobes from the front end
   typedef struct packed {
      logic lock_prog;
      logic pw_prog;
      logic pw_start;
      logic pw_byte;
      logic pw_done;
      logic ppb_prog;
      logic ppb_erase;
      logic plk_set;
      logic dyb_set;
      logic dyb_clr;
   } stb_t;

   function automatic set_e code_to_set(input logic [7:0] c);
      case (c)
         8'h40:   return SET_LOCK;
         8'h60:   return SET_PWD;
         8'hC0:   return SET_PPB;
         8'h50:   return SET_PLK;
         8'hE0:   return SET_DYB;
         default: return SET_RD;
      endcase
   endfunction

endpackage

// File: rtl/fps_cmd_front.sv
module fps_cmd_front
   import fps_pkg::*;
#(
   parameter int CMP_W    = 12,
   parameter int PW_BYTES = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CMP_W-1:0] cmd_adr,
   input  logic [7:0]       wdata,
   output set_e             mode,
   output stb_t             stb
);

   localparam int CNT_W = $clog2(PW_BYTES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PW_BYTES - 1);

   if (CMP_W != 12) begin : g_bad_cmp
      $error("fps_cmd_front: command field must be 12 bits");
   end

   typedef enum logic [3:0] {
      F_IDLE, F_U1, F_U2, F_SET, F_ARG, F_EX, F_ER, F_PW1, F_PW2, F_PW3
   } fst_e;

   fst_e             st, st_n;
   set_e             mode_n;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      st_n   = st;
      mode_n = mode;
      stb    = '0;
      if (wr_en) begin
         case (st)
            F_IDLE: if (wdata == KEY_A && cmd_adr == CMD_ADR_A) st_n = F_U1;
            F_U1: st_n = (wdata == KEY_B && cmd_adr == CMD_ADR_B) ? F_U2 : F_IDLE;
            F_U2: begin
               st_n = F_IDLE;
               if (cmd_adr == CMD_ADR_A && code_to_set(wdata) != SET_RD) begin
                  mode_n = code_to_set(wdata);
                  st_n   = F_SET;
               end
            end
            F_SET: begin
               if (wdata == OP_PROG)                          st_n = F_ARG;
               else if (wdata == OP_EXIT)                     st_n = F_EX;
               else if (wdata == OP_ERASE && mode == SET_PPB) st_n = F_ER;
               else if (wdata == OP_PWU_A && mode == SET_PWD) st_n = F_PW1;
            end
            F_ARG: begin
               st_n = F_SET;
               case (mode)
                  SET_LOCK: begin
                     if (wdata[2:1] == 2'b00) begin
                        st_n   = F_IDLE;
                        mode_n = SET_RD;
                     end else begin
                        stb.lock_prog = 1'b1;
                     end
                  end
                  SET_PWD: stb.pw_prog  = 1'b1;
                  SET_PPB: stb.ppb_prog = (wdata == 8'h00);
                  SET_PLK: stb.plk_set  = (wdata == 8'h00);
                  SET_DYB: begin
                     stb.dyb_set = (wdata == 8'h00);
                     stb.dyb_clr = (wdata == 8'h01);
                  end
                  default: st_n = F_IDLE;
               endcase
            end
            F_EX: begin
               if (wdata == 8'h00) begin
                  st_n   = F_IDLE;
                  mode_n = SET_RD;
               end else begin
                  st_n = F_SET;
               end
            end
            F_ER: begin
               stb.ppb_erase = (wdata == OP_ERGO);
               st_n          = F_SET;
            end
            F_PW1: begin
               stb.pw_start = (wdata == OP_PWU_B);
               st_n         = (wdata == OP_PWU_B) ? F_PW2 : F_SET;
            end
            F_PW2: begin
               stb.pw_byte = 1'b1;
               if (cnt_q == CNT_LAST) st_n = F_PW3;
            end
            F_PW3: begin
               stb.pw_done = (wdata == OP_PWU_Z);
               st_n        = F_SET;
            end
            default: st_n = F_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= F_IDLE;
         mode  <= SET_RD;
         cnt_q <= '0;
      end else begin
         st   <= st_n;
         mode <= mode_n;
         if (stb.pw_start)     cnt_q <= '0;
         else if (stb.pw_byte) cnt_q <= cnt_q + 1'b1;
      end
   end

   // R5
   lock_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && st == F_ARG && mode == SET_LOCK && wdata[2:1] == 2'b00) |=> (mode == SET_RD));

   // R3
   exit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && st == F_EX && wdata == 8'h00) |=> (mode == SET_RD));

   // R2
   entry_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != SET_RD && $past(mode) == SET_RD) |-> ($past(st) == F_U2 && $past(wr_en)));

endmodule

// File: rtl/fps_password.sv
module fps_password #(
   parameter int PW_BYTES = 8,
   parameter int IDX_W    = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prog,
   input  logic             start,
   input  logic             byte_stb,
   input  logic             done,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       wdata,
   output logic [7:0]       rd_byte,
   output logic             unlock
);

   if (PW_BYTES != (1 << IDX_W)) begin : g_bad_idx
      $error("fps_password: byte count must equal 2**IDX_W");
   end

   logic [7:0]          pw_q [PW_BYTES];
   logic [PW_BYTES-1:0] cov_q;
   logic                miss_q;

   for (genvar g = 0; g < PW_BYTES; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          pw_q[g] <= 8'hFF;
         else if (prog && idx == IDX_W'(g))   pw_q[g] <= pw_q[g] & wdata;
      end

      // R6
      pw_otp_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pw_q[g] & ~$past(pw_q[g])) == 8'h00);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cov_q  <= '0;
         miss_q <= 1'b0;
      end else if (start) begin
         cov_q  <= '0;
         miss_q <= 1'b0;
      end else if (byte_stb) begin
         cov_q[idx] <= 1'b1;
         if (wdata != pw_q[idx]) miss_q <= 1'b1;
      end
   end

   assign unlock  = done && (&cov_q) && !miss_q;
   assign rd_byte = pw_q[idx];

endmodule

// File: rtl/fps_sector_bits.sv
module fps_sector_bits #(
   parameter int SECTORS = 8,
   parameter int SECT_W  = 3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SECT_W-1:0]  sa,
   input  logic               ppb_en,
   input  logic               ppb_prog,
   input  logic               ppb_erase,
   input  logic               dyb_set,
   input  logic               dyb_clr,
   output logic [SECTORS-1:0] ppb_q,
   output logic [SECTORS-1:0] dyb_q
);

   if (SECTORS != (1 << SECT_W)) begin : g_bad_sect
      $error("fps_sector_bits: sector count must equal 2**SECT_W");
   end

   for (genvar g = 0; g < SECTORS; g++) begin : g_sect
      logic hit;
      assign hit = (sa == SECT_W'(g));

      // erase pre-programs and erases in one step; the net result is clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          ppb_q[g] <= 1'b0;
         else if (ppb_en && ppb_erase)        ppb_q[g] <= 1'b0;
         else if (ppb_en && ppb_prog && hit)  ppb_q[g] <= 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             dyb_q[g] <= 1'b0;
         else if (dyb_set && hit)                dyb_q[g] <= 1'b1;
         else if (dyb_clr && hit && !ppb_q[g])   dyb_q[g] <= 1'b0;
      end

      // R11
      dyb_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dyb_clr && hit && ppb_q[g] && dyb_q[g]) |=> dyb_q[g]);
   end

   // R10
   ppb_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ppb_prog || ppb_erase) && !ppb_en) |=> $stable(ppb_q));

endmodule

// File: rtl/flash_prot_seq.sv
module flash_prot_seq
   import fps_pkg::*;
#(
   parameter int SECTORS = 8
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic                              rd_en,
   input  logic [12+$clog2(SECTORS)-1:0]     addr,
   input  logic [7:0]                        wdata,
   output logic [7:0]                        rd_data,
   output logic [2:0]                        cmd_mode
);

   localparam int CMP_W    = 12;
   localparam int SECT_W   = $clog2(SECTORS);
   localparam int ADDR_W   = CMP_W + SECT_W;
   localparam int PW_BYTES = 8;
   localparam int IDX_W    = $clog2(PW_BYTES);
   localparam int LOCK_W   = 3;

   if (SECTORS < 2 || SECTORS > 1024) begin : g_bad_cnt
      $error("flash_prot_seq: SECTORS out of range");
   end

   set_e               mode;
   stb_t               stb;
   logic [SECT_W-1:0]  sa;
   logic [7:0]         pw_byte;
   logic               pw_unlock;
   logic [SECTORS-1:0] ppb_q, dyb_q;
   logic [LOCK_W-1:0]  lock_q;
   logic               plk_q;

   assign sa       = addr[ADDR_W-1 -: SECT_W];
   assign cmd_mode = mode;

   fps_cmd_front #(.CMP_W(CMP_W), .PW_BYTES(PW_BYTES)) u_front (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .cmd_adr (addr[CMP_W-1:0]),
      .wdata   (wdata),
      .mode    (mode),
      .stb     (stb)
   );

   fps_password #(.PW_BYTES(PW_BYTES), .IDX_W(IDX_W)) u_pw (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog     (stb.pw_prog),
      .start    (stb.pw_start),
      .byte_stb (stb.pw_byte),
      .done     (stb.pw_done),
      .idx      (addr[IDX_W-1:0]),
      .wdata    (wdata),
      .rd_byte  (pw_byte),
      .unlock   (pw_unlock)
   );

   fps_sector_bits #(.SECTORS(SECTORS), .SECT_W(SECT_W)) u_sect (
      .clk       (clk),
      .rst_n     (rst_n),
      .sa        (sa),
      .ppb_en    (!plk_q),
      .ppb_prog  (stb.ppb_prog),
      .ppb_erase (stb.ppb_erase),
      .dyb_set   (stb.dyb_set),
      .dyb_clr   (stb.dyb_clr),
      .ppb_q     (ppb_q),
      .dyb_q     (dyb_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= '1;
         plk_q  <= 1'b0;
      end else begin
         if (stb.lock_prog) lock_q <= lock_q & wdata[LOCK_W-1:0];
         if (stb.plk_set)   plk_q  <= 1'b1;
         else if (pw_unlock) plk_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= 8'hFF;
      end else if (rd_en) begin
         case (mode)
            SET_LOCK: rd_data <= {{(8-LOCK_W){1'b1}}, lock_q};
            SET_PWD:  rd_data <= pw_byte;
            SET_PPB:  rd_data <= {7'b0, ~ppb_q[sa]};
            SET_PLK:  rd_data <= {7'b0, ~plk_q};
            SET_DYB:  rd_data <= {7'b0, ~dyb_q[sa]};
            default:  rd_data <= 8'hFF;
         endcase
      end
   end

   // R4
   lock_otp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q & ~$past(lock_q)) == '0);

   // R12
   status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (mode == SET_PPB || mode == SET_PLK || mode == SET_DYB)) |=> (rd_data[7:1] == 7'b0));

   // R7
   plk_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(plk_q) |-> ($past(mode) == SET_PWD));

endmodule

// File: tb/sim_flash_prot_seq.sv
`timescale 1ns/1ps
module sim_flash_prot_seq;

   localparam int AW = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rd_data;
   logic [2:0]    cmd_mode;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   flash_prot_seq #(.SECTORS(8)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rd_data(rd_data), .cmd_mode(cmd_mode)
   );

   // entry: op(2) 0=write 1=read-check 2=mode-check, addr(15), data(8), expected(8), req(4)
   localparam int NV = 43;
   localparam logic [36:0] VEC [NV] = '{
      // R2 R11: volatile bits set/clear
      {2'd0,15'h0AAA,8'hAA,8'h00,4'd2},
      {2'd0,15'h0555,8'h55,8'h00,4'd2},
      {2'd0,15'h0AAA,8'hE0,8'h00,4'd2},
      {2'd2,15'h0000,8'h00,8'h05,4'd2},
      {2'd1,15'h2000,8'h00,8'h01,4'd11},
      {2'd0,15'h0000,8'hA0,8'h00,4'd11},
      {2'd0,15'h2000,8'h00,8'h00,4'd11},
      {2'd1,15'h2000,8'h00,8'h00,4'd11},
      {2'd1,15'h3000,8'h00,8'h01,4'd11},
      {2'd0,15'h0000,8'hA0,8'h00,4'd11},
      {2'd0,15'h2000,8'h01,8'h00,4'd11},
      {2'd1,15'h2000,8'h00,8'h01,4'd11},
      // R3 exit, R12 array read
      {2'd0,15'h0000,8'h90,8'h00,4'd3},
      {2'd0,15'h0000,8'h00,8'h00,4'd3},
      {2'd2,15'h0000,8'h00,8'h00,4'd3},
      {2'd1,15'h0000,8'h00,8'hFF,4'd12},
      // R8 R9: persistent bits
      {2'd0,15'h0AAA,8'hAA,8'h00,4'd8},
      {2'd0,15'h0555,8'h55,8'h00,4'd8},
      {2'd0,15'h0AAA,8'hC0,8'h00,4'd8},
      {2'd2,15'h0000,8'h00,8'h03,4'd8},
      {2'd0,15'h0000,8'hA0,8'h00,4'd8},
      {2'd0,15'h1000,8'h00,8'h00,4'd8},
      {2'd1,15'h1000,8'h00,8'h00,4'd8},
      {2'd1,15'h0000,8'h00,8'h01,4'd8},
      {2'd0,15'h0000,8'h80,8'h00,4'd9},
      {2'd0,15'h0000,8'h30,8'h00,4'd9},
      {2'd1,15'h1000,8'h00,8'h01,4'd9},
      {2'd0,15'h0000,8'hA0,8'h00,4'd8},
      {2'd0,15'h7000,8'h00,8'h00,4'd8},
      {2'd1,15'h7000,8'h00,8'h00,4'd8},
      {2'd0,15'h0000,8'h90,8'h00,4'd3},
      {2'd0,15'h0000,8'h00,8'h00,4'd3},
      // R11: clear refused on persistently protected sector
      {2'd0,15'h0AAA,8'hAA,8'h00,4'd11},
      {2'd0,15'h0555,8'h55,8'h00,4'd11},
      {2'd0,15'h0AAA,8'hE0,8'h00,4'd11},
      {2'd0,15'h0000,8'hA0,8'h00,4'd11},
      {2'd0,15'h7000,8'h00,8'h00,4'd11},
      {2'd0,15'h0000,8'hA0,8'h00,4'd11},
      {2'd0,15'h7000,8'h01,8'h00,4'd11},
      {2'd1,15'h7000,8'h00,8'h00,4'd11},
      {2'd0,15'h0000,8'h90,8'h00,4'd3},
      {2'd0,15'h0000,8'h00,8'h00,4'd3},
      {2'd2,15'h0000,8'h00,8'h00,4'd3}
   };

   task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      check8(rd_data, exp, req);
   endtask

   task automatic mode_chk(input logic [2:0] exp, input string req);
      check8({5'b0, cmd_mode}, {5'b0, exp}, req);
   endtask

   task automatic enter(input logic [7:0] code);
      wr(15'h0AAA, 8'hAA);
      wr(15'h0555, 8'h55);
      wr(15'h0AAA, code);
   endtask

   task automatic leave();
      wr(15'h0000, 8'h90);
      wr(15'h0000, 8'h00);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      mode_chk(3'd0, "R1");
      rd_chk(15'h0000, 8'hFF, "R1");
      enter(8'h40);
      rd_chk(15'h0000, 8'hFF, "R1");
      leave();
      enter(8'h50);
      rd_chk(15'h0000, 8'h01, "R1");
      leave();
      enter(8'hC0);
      rd_chk(15'h5000, 8'h01, "R1");
      leave();

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [36:0] e;
         string tag;
         e = VEC[i];
         tag = $sformatf("R%0d", e[3:0]);
         case (e[36:35])
            2'd0: wr(e[34:20], e[19:12]);
            2'd1: rd_chk(e[34:20], e[11:4], tag);
            default: mode_chk(e[6:4], tag);
         endcase
      end

      // R2 broken prefix and unknown code stay in read mode
      wr(15'h0AAA, 8'hAA);
      wr(15'h0554, 8'h55);
      wr(15'h0AAA, 8'hC0);
      mode_chk(3'd0, "R2");
      enter(8'h33);
      mode_chk(3'd0, "R2");
      // R2 upper address bits ignored
      wr(15'h5AAA, 8'hAA);
      wr(15'h7555, 8'h55);
      wr(15'h2AAA, 8'hE0);
      mode_chk(3'd5, "R2");
      leave();

      // R3 stray writes keep the set
      enter(8'hC0);
      wr(15'h0000, 8'h90);
      wr(15'h0000, 8'h12);
      mode_chk(3'd3, "R3");
      wr(15'h0000, 8'h44);
      mode_chk(3'd3, "R3");
      leave();
      mode_chk(3'd0, "R3");

      // R4 R5 lock register
      enter(8'h40);
      mode_chk(3'd1, "R4");
      wr(15'h0000, 8'hA0); wr(15'h0000, 8'hFE);
      rd_chk(15'h0000, 8'hFE, "R4");
      wr(15'h0000, 8'hA0); wr(15'h0000, 8'h05);
      rd_chk(15'h0000, 8'hFC, "R4");
      wr(15'h0000, 8'hA0); wr(15'h0000, 8'hF9);
      mode_chk(3'd0, "R5");
      enter(8'h40);
      rd_chk(15'h0000, 8'hFC, "R5");
      leave();

      // R6 password program and read
      enter(8'h60);
      mode_chk(3'd2, "R6");
      for (int k = 0; k < 8; k++) begin
         wr(15'h0000, 8'hA0);
         wr(AW'(k), 8'(8'h10 + k));
      end
      rd_chk(15'h0003, 8'h13, "R6");
      wr(15'h0000, 8'hA0); wr(15'h0000, 8'hF1);
      rd_chk(15'h0000, 8'h10, "R6");
      rd_chk(15'h0007, 8'h17, "R6");
      leave();

      // R10 lock freezes persistent bits
      enter(8'h50);
      wr(15'h0000, 8'hA0); wr(15'h0000, 8'h00);
      rd_chk(15'h0000, 8'h00, "R10");
      leave();
      enter(8'hC0);
      wr(15'h0000, 8'hA0); wr(15'h4000, 8'h00);
      rd_chk(15'h4000, 8'h01, "R10");
      wr(15'h0000, 8'h80); wr(15'h0000, 8'h30);
      rd_chk(15'h7000, 8'h00, "R10");
      leave();

      // R7 wrong byte: stays locked
      enter(8'h60);
      wr(15'h0000, 8'h25); wr(15'h0000, 8'h03);
      for (int k = 0; k < 8; k++) wr(AW'(k), (k == 5) ? 8'h99 : 8'(8'h10 + k));
      wr(15'h0000, 8'h29);
      leave();
      enter(8'h50);
      rd_chk(15'h0000, 8'h00, "R7");
      leave();
      // R7 index 7 never supplied: stays locked
      enter(8'h60);
      wr(15'h0000, 8'h25); wr(15'h0000, 8'h03);
      for (int k = 0; k < 8; k++) begin
         int ix;
         ix = (k == 7) ? 0 : k;
         wr(AW'(ix), 8'(8'h10 + ix));
      end
      wr(15'h0000, 8'h29);
      leave();
      enter(8'h50);
      rd_chk(15'h0000, 8'h00, "R7");
      leave();
      // R7 correct bytes in reverse order: unlocks
      enter(8'h60);
      wr(15'h0000, 8'h25); wr(15'h0000, 8'h03);
      for (int k = 7; k >= 0; k--) wr(AW'(k), 8'(8'h10 + k));
      wr(15'h0000, 8'h29);
      leave();
      enter(8'h50);
      rd_chk(15'h0000, 8'h01, "R7");
      leave();
      enter(8'hC0);
      wr(15'h0000, 8'h80); wr(15'h0000, 8'h30);
      rd_chk(15'h7000, 8'h01, "R9");
      leave();
      rd_chk(15'h7000, 8'hFF, "R12");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule